// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects fifteen single-bit interrupt sources, numbered 1 to 15, and holds each event in its own pending bit. Two mask registers decide which pending sources may interrupt the CPU. A global enable bit in a flag register held inside the block gates the request. When several enabled sources are pending, the lowest source number wins. The vector for source `n` is `n * 4`.

When the CPU accepts the request, the block runs a fixed 13-cycle acknowledge sequence. It pushes the return PC (high byte, then low byte) and the flag register onto an external byte stack, then clears the flags. In the last cycle it loads the PC with the vector. A return command runs the reverse: it pops the flags, then the PC low byte, then the PC high byte, and loads the PC with the restored address. Because acknowledge clears the global enable, a handler can only be interrupted again if software sets the enable bit itself.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_evt[i]` sets the pending bit of source `i+1`. That bit stays set until the source is acknowledged, the vector-clear register is written, or reset is applied.
- R2: `irq_req` is 1 exactly when at least one pending source has its mask bit set, flag bit 0 (the global enable) is 1, and no sequence is running.
- R3: A write with `cfg_sel`=1 sets the digital mask, where bit k enables source 2+k (k = 0..7). A write with `cfg_sel`=0 sets the general mask: bit 0 enables source 1, bits 1..4 enable sources 10..13, bit 5 enables source 14 and bit 6 enables source 15.
- R4: `vec_rdata` equals 4 times the lowest-numbered pending, unmasked source, or 0 if there is none. The global enable plays no part in this value.
- R5: A write with `cfg_sel`=2, whatever the data, clears every pending bit in one cycle.
- R6: If a source pulses in the same cycle its pending bit is cleared, whether by acknowledge or by the clear-all write, the bit ends up set.
- R7: `ack_start` sampled while `irq_req`=1 starts a sequence with `busy` high for 13 cycles, and clears the chosen source's pending bit at once. The sequence pushes `pc_in[15:8]`, `pc_in[7:0]` and then the flags in its first three cycles. The flags read 0 from the fourth cycle on. `pc_load` is asserted in the 13th cycle with `pc_load_addr` set to the vector.
- R8: The source delivered is the one chosen when `ack_start` is accepted. Sources arriving during the sequence stay pending and do not change the vector.
- R9: `reti` sampled while idle runs a 3-cycle sequence. The first cycle pops and restores the flags, the second pops the PC low byte, and the third pops the PC high byte with `pc_load` asserted at `{high, low}`. If `reti` and `ack_start` arrive together, `reti` wins.
- R10: While `busy` is high, `ack_start`, `reti` and flag writes are ignored. `ack_start` is also ignored while `irq_req` is 0.
- R11: After a synchronous reset, all pending bits, both masks and the flags are 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 15 | Source pulses; bit i is source i+1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 general mask, 1 digital mask, 2 clear all pending |
| cfg_wdata | input | 8 | Register write data |
| vec_rdata | output | 8 | Current best vector, or 0 |
| flag_we | input | 1 | Flag register write strobe |
| flag_wdata | input | 8 | Flag register write data |
| flags | output | 8 | Flag register; bit 0 is the global enable |
| irq_req | output | 1 | Interrupt request to the CPU |
| ack_start | input | 1 | CPU accepts the request |
| reti | input | 1 | Return-from-interrupt command |
| busy | output | 1 | Acknowledge or return sequence running |
| pc_in | input | 16 | Return PC to save |
| pc_load | output | 1 | Load the PC this cycle |
| pc_load_addr | output | 16 | Address to load |
| stk_push | output | 1 | Push `stk_wdata` onto the stack |
| stk_wdata | output | 8 | Byte to push |
| stk_pop | output | 1 | Pop the stack; top byte is read this cycle |
| stk_rdata | input | 8 | Current top-of-stack byte |

## Verification
A source event can land in the same cycle its pending bit is being cleared. The clear can come from an acknowledge of that source or from a clear-all write. The bench provokes both cases by driving the source pulse in the same cycle as `ack_start`, and again in the same cycle as the clear-all write. It then judges the result at the ports: once the sequence has ended, `vec_rdata` must still show that source's vector. A second overlap is a new source arriving while an acknowledge is in flight. The bench checks that the delivered vector is unchanged and that the newcomer appears on `vec_rdata` afterwards.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC      = 15;
    localparam int SRC_W     = 4;
    localparam int PC_W      = 16;
    localparam int DW        = 8;
    localparam int DIG_FIRST = 2;
    localparam int DIG_NUM   = 8;
    localparam int GEN_NUM   = NSRC - DIG_NUM;
    localparam int ACK_LEN   = 13;
    localparam int RET_LEN   = 3;
    localparam int CNT_W     = $clog2(ACK_LEN);
    localparam int GIE_BIT   = 0;

    typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_RET} seq_st_t;
    typedef enum logic [1:0] {
        CFG_GEN_MASK = 2'd0,
        CFG_DIG_MASK = 2'd1,
        CFG_VEC_CLR  = 2'd2
    } cfg_sel_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] num;
    } pick_t;

    // Spread the two mask registers onto one bit per source (bit i = source i+1)
    function automatic logic [NSRC-1:0] expand_mask(input logic [GEN_NUM-1:0] gen,
                                                    input logic [DIG_NUM-1:0] dig);
        logic [NSRC-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (i + 1 >= DIG_FIRST && i + 1 < DIG_FIRST + DIG_NUM)
                m[i] = dig[i + 1 - DIG_FIRST];
            else if (i + 1 < DIG_FIRST)
                m[i] = gen[i];
            else
                m[i] = gen[i - DIG_NUM];
        end
        return m;
    endfunction

    function automatic logic [PC_W-1:0] vec_of(input logic [SRC_W-1:0] num);
        return PC_W'({num, 2'b00});
    endfunction
endpackage

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_all,
    input  logic [NSRC-1:0] clr_one,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] clr_vec;

    assign clr_vec = clr_all ? '1 : clr_one;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_vec) | evt;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> pend[g]);
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.num   = SRC_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic             ack_start,
    input  logic             reti,
    input  pick_t            pick,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             flag_we,
    input  logic [DW-1:0]    flag_wdata,
    input  logic [DW-1:0]    stk_rdata,
    output logic             busy,
    output logic             ack_take,
    output logic [DW-1:0]    flags,
    output logic             stk_push,
    output logic [DW-1:0]    stk_wdata,
    output logic             stk_pop,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_load_addr
);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_LEN - 1);
    localparam logic [CNT_W-1:0] RET_LAST = CNT_W'(RET_LEN - 1);

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic [SRC_W-1:0] num_q;
    logic [PC_W-1:0]  pc_q;
    logic [DW-1:0]    flag_q;
    logic [DW-1:0]    pcl_q;
    logic             ret_go;

    assign busy     = (st != ST_IDLE);
    assign ret_go   = (st == ST_IDLE) && reti;
    assign ack_take = (st == ST_IDLE) && ack_start && irq_req && !reti;
    assign flags    = flag_q;

    always_comb begin
        stk_push  = (st == ST_ACK) && (cnt <= CNT_W'(2));
        stk_pop   = (st == ST_RET);
        case (cnt)
            CNT_W'(0): stk_wdata = pc_q[PC_W-1:PC_W-DW];
            CNT_W'(1): stk_wdata = pc_q[DW-1:0];
            default:   stk_wdata = flag_q;
        endcase
        pc_load      = ((st == ST_ACK) && (cnt == ACK_LAST)) ||
                       ((st == ST_RET) && (cnt == RET_LAST));
        pc_load_addr = (st == ST_ACK) ? vec_of(num_q) : {stk_rdata, pcl_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            num_q  <= '0;
            pc_q   <= '0;
            flag_q <= '0;
            pcl_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (flag_we) flag_q <= flag_wdata;
                    cnt <= '0;
                    if (ret_go) begin
                        st <= ST_RET;
                    end else if (ack_take) begin
                        st    <= ST_ACK;
                        num_q <= pick.num;
                        pc_q  <= pc_in;
                    end
                end
                ST_ACK: begin
                    if (cnt == CNT_W'(2)) flag_q <= '0;
                    if (cnt == ACK_LAST) st <= ST_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
                ST_RET: begin
                    if (cnt == CNT_W'(0)) flag_q <= stk_rdata;
                    if (cnt == CNT_W'(1)) pcl_q  <= stk_rdata;
                    if (cnt == RET_LAST) st <= ST_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_push && stk_pop));
    // R7
    flags_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && cnt > CNT_W'(2)) |-> (flag_q == '0));
    // R9
    load_ends_seq_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);
    // R10
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ack_start || reti));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_evt,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    vec_rdata,
    input  logic             flag_we,
    input  logic [DW-1:0]    flag_wdata,
    output logic [DW-1:0]    flags,
    output logic             irq_req,
    input  logic             ack_start,
    input  logic             reti,
    output logic             busy,
    input  logic [PC_W-1:0]  pc_in,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_load_addr,
    output logic             stk_push,
    output logic [DW-1:0]    stk_wdata,
    output logic             stk_pop,
    input  logic [DW-1:0]    stk_rdata
);
    logic [GEN_NUM-1:0] gen_mask_q;
    logic [DIG_NUM-1:0] dig_mask_q;
    logic [NSRC-1:0]    pend;
    logic [NSRC-1:0]    clr_one;
    logic               clr_all;
    logic               ack_take;
    pick_t              pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_mask_q <= '0;
            dig_mask_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == CFG_GEN_MASK) gen_mask_q <= cfg_wdata[GEN_NUM-1:0];
            if (cfg_sel == CFG_DIG_MASK) dig_mask_q <= cfg_wdata[DIG_NUM-1:0];
        end
    end

    assign clr_all = cfg_we && (cfg_sel == CFG_VEC_CLR);
    assign clr_one = ack_take ? (NSRC'(1) << (pick.num - 1'b1)) : '0;

    vic_pending u_pend (
        .clk(clk), .rst(rst), .evt(src_evt),
        .clr_all(clr_all), .clr_one(clr_one), .pend(pend)
    );

    vic_prio u_prio (
        .req(pend & expand_mask(gen_mask_q, dig_mask_q)),
        .pick(pick)
    );

    assign vec_rdata = pick.valid ? DW'({pick.num, 2'b00}) : '0;
    assign irq_req   = pick.valid && flags[GIE_BIT] && !busy;

    vic_seq u_seq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ack_start(ack_start),
        .reti(reti), .pick(pick), .pc_in(pc_in), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .stk_rdata(stk_rdata), .busy(busy),
        .ack_take(ack_take), .flags(flags), .stk_push(stk_push),
        .stk_wdata(stk_wdata), .stk_pop(stk_pop), .pc_load(pc_load),
        .pc_load_addr(pc_load_addr)
    );

    // R2
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (flags[GIE_BIT] && !busy && vec_rdata != '0));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] src_evt;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [7:0]  vec_rdata;
    logic        flag_we;
    logic [7:0]  flag_wdata;
    logic [7:0]  flags;
    logic        irq_req, ack_start, reti, busy;
    logic [15:0] pc_in;
    logic        pc_load;
    logic [15:0] pc_load_addr;
    logic        stk_push, stk_pop;
    logic [7:0]  stk_wdata, stk_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] smem [0:7];
    int sp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .vec_rdata(vec_rdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .flags(flags),
        .irq_req(irq_req), .ack_start(ack_start), .reti(reti), .busy(busy),
        .pc_in(pc_in), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
        .stk_push(stk_push), .stk_wdata(stk_wdata), .stk_pop(stk_pop),
        .stk_rdata(stk_rdata)
    );

    // Byte stack model
    assign stk_rdata = (sp > 0) ? smem[sp-1] : 8'h00;
    always @(posedge clk) begin
        if (stk_push) begin
            smem[sp] <= stk_wdata;
            sp <= sp + 1;
        end else if (stk_pop && sp > 0) begin
            sp <= sp - 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_src(input logic [14:0] m);
        src_evt = m;
        step();
        src_evt = '0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic flag_write(input logic [7:0] d);
        flag_we = 1'b1; flag_wdata = d;
        step();
        flag_we = 1'b0;
    endtask

    // Runs an acknowledge; returns the sample index of pc_load and its address
    task automatic run_ack(input logic [14:0] evt_at_start, output int lj,
                           output logic [15:0] la);
        lj = -1; la = '0;
        ack_start = 1'b1; src_evt = evt_at_start;
        step();
        ack_start = 1'b0; src_evt = '0;
        for (int j = 0; j < 16; j++) begin
            if (pc_load) begin lj = j; la = pc_load_addr; end
            step();
        end
    endtask

    task automatic run_reti(output int lj, output logic [15:0] la);
        lj = -1; la = '0;
        reti = 1'b1;
        step();
        reti = 1'b0;
        for (int j = 0; j < 6; j++) begin
            if (pc_load) begin lj = j; la = pc_load_addr; end
            step();
        end
    endtask

    task automatic t_reset();
        chk("R11 irq_req", irq_req, 0);
        chk("R11 busy", busy, 0);
        chk("R11 flags", flags, 0);
        chk("R11 vec_rdata", vec_rdata, 0);
        chk("R11 pc_load", pc_load, 0);
    endtask

    task automatic t_mask_gate();
        pulse_src(15'h0004);            // source 3
        step(); step();
        chk("R1 masked pending hidden", vec_rdata, 0);
        cfg_write(2'd1, 8'h02);         // digital bit1 -> source 3
        chk("R3 digital mask", vec_rdata, 12);
        chk("R2 no request without enable", irq_req, 0);
        flag_write(8'h01);
        chk("R2 request with enable", irq_req, 1);
        pulse_src(15'h0001);            // source 1
        chk("R3 general mask off", vec_rdata, 12);
        cfg_write(2'd0, 8'h01);
        chk("R4 source1 wins", vec_rdata, 4);
        cfg_write(2'd0, 8'h20);         // bit5 -> source 14
        pulse_src(15'h2000);
        chk("R3 general bit5 is source14", vec_rdata, 12);
    endtask

    task automatic t_prio_clear();
        cfg_write(2'd1, 8'hFF);
        cfg_write(2'd0, 8'h7F);
        pulse_src(15'h2010);            // sources 14 and 5
        chk("R4 lowest pending", vec_rdata, 4);
        cfg_write(2'd2, 8'h00);
        chk("R5 clear all vector", vec_rdata, 0);
        chk("R5 clear all request", irq_req, 0);
        pulse_src(15'h2010);
        chk("R4 priority 5 over 14", vec_rdata, 20);
    endtask

    task automatic t_ack();
        int lj; logic [15:0] la;
        pc_in = 16'h1234;
        ack_start = 1'b1;
        step();
        ack_start = 1'b0;
        chk("R7 busy after accept", busy, 1);
        chk("R7 chosen pending cleared", vec_rdata, 56);
        chk("R2 no request while busy", irq_req, 0);
        lj = -1; la = '0;
        for (int j = 0; j < 16; j++) begin
            if (pc_load) begin lj = j; la = pc_load_addr; end
            src_evt = (j == 1) ? 15'h0002 : 15'h0000;   // source 2 arrives late
            step();
        end
        src_evt = '0;
        chk("R7 load cycle", lj, 12);
        chk("R8 vector frozen", la, 16'h0014);
        chk("R7 busy done", busy, 0);
        chk("R7 flags cleared", flags, 0);
        chk("R7 stack depth", sp, 3);
        chk("R7 push pc high", smem[0], 8'h12);
        chk("R7 push pc low", smem[1], 8'h34);
        chk("R7 push flags", smem[2], 8'h01);
        chk("R8 late source pending", vec_rdata, 8);
    endtask

    task automatic t_reti();
        int lj; logic [15:0] la;
        run_reti(lj, la);
        chk("R9 load cycle", lj, 2);
        chk("R9 return address", la, 16'h1234);
        chk("R9 flags restored", flags, 8'h01);
        chk("R9 stack empty", sp, 0);
        chk("R9 request again", irq_req, 1);
    endtask

    task automatic t_set_wins();
        int lj; logic [15:0] la;
        cfg_we = 1'b1; cfg_sel = 2'd2; src_evt = 15'h0040;   // source 7
        step();
        cfg_we = 1'b0; src_evt = '0;
        chk("R6 set beats clear all", vec_rdata, 28);
        pc_in = 16'h0200;
        run_ack(15'h0040, lj, la);
        chk("R7 vector source7", la, 16'h001C);
        chk("R6 set beats ack clear", vec_rdata, 28);
        run_reti(lj, la);
        chk("R9 return 0x0200", la, 16'h0200);
    endtask

    task automatic t_ignore();
        int lj; logic [15:0] la;
        cfg_write(2'd2, 8'h00);
        ack_start = 1'b1;
        step();
        ack_start = 1'b0;
        chk("R10 ack without request", busy, 0);
        pulse_src(15'h0040);
        pc_in = 16'h0300;
        ack_start = 1'b1; reti = 1'b1;
        step();
        ack_start = 1'b0; reti = 1'b0;
        for (int j = 0; j < 4; j++) step();
        chk("R9 reti beats ack", vec_rdata, 28);
        chk("R9 reti beats ack flags", flags, 8'h00);
        flag_write(8'h01);
        ack_start = 1'b1;
        step();
        ack_start = 1'b0;
        lj = -1; la = '0;
        for (int j = 0; j < 16; j++) begin
            if (pc_load) begin lj = j; la = pc_load_addr; end
            flag_we = (j == 5); flag_wdata = 8'hFF;
            reti    = (j == 6);
            step();
        end
        flag_we = 1'b0; reti = 1'b0;
        chk("R10 flag write ignored", flags, 8'h00);
        chk("R10 reti ignored while busy", sp, 3);
        chk("R10 delivered", la, 16'h001C);
        run_reti(lj, la);
        chk("R10 cleanup return", la, 16'h0300);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_evt = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        flag_we = 1'b0; flag_wdata = '0; ack_start = 1'b0; reti = 1'b0; pc_in = '0;
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_mask_gate();
        t_prio_clear();
        t_ack();
        t_reti();
        t_set_wins();
        t_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule